// File: doc/BRIEF.md
# Bank-Based Address Translation Unit

This block maps a 16-bit logical address from a processor core onto a 20-bit physical address. The logical space is cut into 16 pages of 4 KB. The page number is the top four address bits. One packed boundary register holds two page numbers that split the space into three regions:
- a low region that passes through unchanged;
- a middle region that is offset by a bank base;
- an upper region that is offset by a common base.

The 12-bit offset inside a page is never altered.

Software loads the three 8-bit registers through a small write port. Each load also rebuilds a registered 16-entry table of physical page numbers. The rebuild uses the register values being written, so the new mapping holds from the clock edge that takes the write. Translation is a single table lookup. It is combinational from the logical address to the physical address, so a core can present an address and use the translated result within the same cycle.

Top module: `addr_xlate_unit`

## Requirements
- R1: Physical address bits 11:0 always equal logical address bits 11:0.
- R2: After reset the boundary register is 0xF0 and both base registers are 0, so every logical address maps to the physical address with the same value and bits 19:16 at zero.
- R3: A page whose number (logical bits 15:12) is below the bank start page (boundary register bits 3:0) maps to physical page number equal to the logical page number.
- R4: A page at or above the bank start page and below the common start page (boundary register bits 7:4) maps to physical page = logical page + bank base register.
- R5: A page at or above both the bank start page and the common start page maps to physical page = logical page + common base register.
- R6: The physical page sum is kept to 8 bits, so a result of 0x100 or more wraps modulo 1 MB.
- R7: A write with select 0 (boundary), 1 (bank base) or 2 (common base) changes the mapping for translations in the cycle after its clock edge. A translation in the same cycle as the write still uses the old mapping.
- R8: A write with select 3 changes no register and no mapping.
- R9: When the common start page is below the bank start page, pages below the bank start stay one-to-one, and pages at or above both boundaries use the common base. This holds even for pages at or above the common start.
- R10: With the write enable low, the select and data inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 boundary, 1 bank base, 2 common base, 3 none |
| regWrData | input | 8 | Register write data |
| logAddr | input | 16 | Logical address |
| physAddr | output | 20 | Translated physical address |

## Verification
A register write and a translation can fall in the same cycle. Translation is combinational from the table, and the table is reloaded on the write edge. The bench holds a logical address in the middle region and, in that same cycle, writes a new bank base. It then samples the physical address twice. The sample before the edge must show the old base, and the sample after the edge must show the new one, with no cycle of stale data in between.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;

  // register select codes on the write port
  typedef enum logic [1:0] {
    SEL_AREA   = 2'd0,
    SEL_BANK   = 2'd1,
    SEL_COMMON = 2'd2,
    SEL_NONE   = 2'd3
  } xlate_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldArea;
    logic ldBank;
    logic ldCommon;
    logic rebuild;
  } xlate_strobe_t;

endpackage

// File: rtl/xlate_ctrl.sv
`timescale 1ns/1ps
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic                 regWrEn,
  input  logic [1:0]           regSel,
  output xlate_strobe_t        strb
);

  xlate_sel_e selCode;

  always_comb begin
    selCode = xlate_sel_e'(regSel);
    strb = '0;
    if (regWrEn) begin
      unique case (selCode)
        SEL_AREA:   strb.ldArea   = 1'b1;
        SEL_BANK:   strb.ldBank   = 1'b1;
        SEL_COMMON: strb.ldCommon = 1'b1;
        default:    ;
      endcase
    end
    strb.rebuild = strb.ldArea | strb.ldBank | strb.ldCommon;
  end

endmodule

// File: rtl/xlate_datapath.sv
`timescale 1ns/1ps
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int OFFS_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  xlate_strobe_t                     strb,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [LOG_W-1:0]                  logAddr,
  output logic [PHYS_W-1:0]                 physAddr,
  output logic [2*(LOG_W-OFFS_W)-1:0]       areaReg,
  output logic [PHYS_W-OFFS_W-1:0]          bankReg,
  output logic [PHYS_W-OFFS_W-1:0]          commonReg
);

  localparam int PAGE_W    = LOG_W - OFFS_W;
  localparam int PPAGE_W   = PHYS_W - OFFS_W;
  localparam int NUM_PAGES = 1 << PAGE_W;
  localparam int AREA_W    = 2 * PAGE_W;
  localparam logic [AREA_W-1:0] AREA_RST = {{PAGE_W{1'b1}}, {PAGE_W{1'b0}}};

  logic [AREA_W-1:0]  nextArea;
  logic [PPAGE_W-1:0] nextBank;
  logic [PPAGE_W-1:0] nextCommon;
  logic [PAGE_W-1:0]  bankStart;
  logic [PAGE_W-1:0]  commonStart;
  logic [PPAGE_W-1:0] nextTbl [NUM_PAGES];
  logic [PPAGE_W-1:0] pageTbl [NUM_PAGES];

  // write-through values: the rebuild sees the data being written
  assign nextArea    = strb.ldArea   ? wrData[AREA_W-1:0]  : areaReg;
  assign nextBank    = strb.ldBank   ? wrData[PPAGE_W-1:0] : bankReg;
  assign nextCommon  = strb.ldCommon ? wrData[PPAGE_W-1:0] : commonReg;
  assign bankStart   = nextArea[PAGE_W-1:0];
  assign commonStart = nextArea[AREA_W-1:PAGE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      areaReg   <= AREA_RST;
      bankReg   <= '0;
      commonReg <= '0;
    end else begin
      areaReg   <= nextArea;
      bankReg   <= nextBank;
      commonReg <= nextCommon;
    end
  end

  // one page-base calculator per logical page
  for (genvar pg = 0; pg < NUM_PAGES; pg++) begin : g_page
    localparam logic [PAGE_W-1:0]  PG_NUM = PAGE_W'(pg);
    localparam logic [PPAGE_W-1:0] PG_EXT = PPAGE_W'(pg);
    logic inBank;
    logic inCommon;
    assign inBank   = (PG_NUM >= bankStart);
    assign inCommon = inBank && (PG_NUM >= commonStart);
    always_comb begin
      if (inCommon)
        nextTbl[pg] = PG_EXT + nextCommon;
      else if (inBank)
        nextTbl[pg] = PG_EXT + nextBank;
      else
        nextTbl[pg] = PG_EXT;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_PAGES; k++) begin
      if (!rstN)
        pageTbl[k] <= PPAGE_W'(k);
      else if (strb.rebuild)
        pageTbl[k] <= nextTbl[k];
    end
  end

  assign physAddr = {pageTbl[logAddr[LOG_W-1:OFFS_W]], logAddr[OFFS_W-1:0]};

endmodule

// File: rtl/addr_xlate_unit.sv
`timescale 1ns/1ps
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int OFFS_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [LOG_W-1:0]  logAddr,
  output logic [PHYS_W-1:0] physAddr
);

  localparam int PAGE_W  = LOG_W - OFFS_W;
  localparam int PPAGE_W = PHYS_W - OFFS_W;

  xlate_strobe_t        strb;
  logic [2*PAGE_W-1:0]  areaReg;
  logic [PPAGE_W-1:0]   bankReg;
  logic [PPAGE_W-1:0]   commonReg;

  xlate_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regSel  (regSel),
    .strb    (strb)
  );

  xlate_datapath #(
    .LOG_W  (LOG_W),
    .PHYS_W (PHYS_W),
    .OFFS_W (OFFS_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (regWrData),
    .logAddr   (logAddr),
    .physAddr  (physAddr),
    .areaReg   (areaReg),
    .bankReg   (bankReg),
    .commonReg (commonReg)
  );

endmodule

// File: rtl/xlate_checker.sv
`timescale 1ns/1ps
module xlate_checker #(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int OFFS_W = 12,
  parameter int DATA_W = 8
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              regWrEn,
  input logic [1:0]                        regSel,
  input logic [DATA_W-1:0]                 regWrData,
  input logic [LOG_W-1:0]                  logAddr,
  input logic [PHYS_W-1:0]                 physAddr,
  input logic [2*(LOG_W-OFFS_W)-1:0]       areaReg,
  input logic [PHYS_W-OFFS_W-1:0]          bankReg,
  input logic [PHYS_W-OFFS_W-1:0]          commonReg
);

  localparam int PAGE_W  = LOG_W - OFFS_W;
  localparam int PPAGE_W = PHYS_W - OFFS_W;

  logic [PAGE_W-1:0]  chkPage;
  logic [PPAGE_W-1:0] chkPhysPage;
  logic [PPAGE_W-1:0] chkPageExt;
  logic               seenWrite;

  assign chkPage     = logAddr[LOG_W-1:OFFS_W];
  assign chkPhysPage = physAddr[PHYS_W-1:OFFS_W];
  assign chkPageExt  = PPAGE_W'(chkPage);

  always_ff @(posedge clk) begin
    if (!rstN)
      seenWrite <= 1'b0;
    else if (regWrEn && regSel != 2'd3)
      seenWrite <= 1'b1;
  end

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[OFFS_W-1:0] == logAddr[OFFS_W-1:0]);

  assert_reset_identity_R2: assert property (@(posedge clk) disable iff (!rstN)
    !seenWrite |-> chkPhysPage == chkPageExt);

  assert_low_identity_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chkPage < areaReg[PAGE_W-1:0]) |-> chkPhysPage == chkPageExt);

  assert_bank_region_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chkPage >= areaReg[PAGE_W-1:0] && chkPage < areaReg[2*PAGE_W-1:PAGE_W])
      |-> chkPhysPage == PPAGE_W'(chkPageExt + bankReg));

  assert_common_region_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chkPage >= areaReg[PAGE_W-1:0] && chkPage >= areaReg[2*PAGE_W-1:PAGE_W])
      |-> chkPhysPage == PPAGE_W'(chkPageExt + commonReg));

  assert_bank_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd1) |=> bankReg == $past(regWrData[PPAGE_W-1:0]));

  assert_sel_none_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd3)
      |=> ($stable(areaReg) && $stable(bankReg) && $stable(commonReg)));

  assert_no_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(areaReg) && $stable(bankReg) && $stable(commonReg)));

endmodule

bind addr_xlate_unit xlate_checker #(
  .LOG_W  (LOG_W),
  .PHYS_W (PHYS_W),
  .OFFS_W (OFFS_W),
  .DATA_W (DATA_W)
) u_xlate_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData),
  .logAddr   (logAddr),
  .physAddr  (physAddr),
  .areaReg   (areaReg),
  .bankReg   (bankReg),
  .commonReg (commonReg)
);

// File: tb/tb_addr_xlate_unit.sv
`timescale 1ns/1ps
module tb_addr_xlate_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [7:0]  regWrData = 8'd0;
  logic [15:0] logAddr = 16'd0;
  logic [19:0] physAddr;

  int nVec = 0;
  int nMis = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  addr_xlate_unit dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .logAddr   (logAddr),
    .physAddr  (physAddr)
  );

  task automatic compare(input logic [19:0] exp, input string req);
    nVec++;
    if (physAddr !== exp) begin
      nMis++;
      $display("FAIL %s: logAddr=%h physAddr=%h expected=%h", req, logAddr, physAddr, exp);
    end
  endtask

  task automatic probe(input logic [15:0] la, input logic [19:0] exp, input string req);
    @(negedge clk);
    logAddr = la;
    #1;
    compare(exp, req);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1;
    regSel = sel;
    regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic test_reset();
    probe(16'h1234, 20'h01234, "R2");
    probe(16'hFFFF, 20'h0FFFF, "R2");
    probe(16'h0000, 20'h00000, "R2");
  endtask

  task automatic test_regions();
    writeReg(2'd0, 8'h84);
    writeReg(2'd1, 8'h10);
    writeReg(2'd2, 8'h30);
    probe(16'h3ABC, 20'h03ABC, "R3");
    probe(16'h4123, 20'h14123, "R4");
    probe(16'h7FFF, 20'h17FFF, "R4");
    probe(16'h8000, 20'h38000, "R5");
    probe(16'hF001, 20'h3F001, "R5");
    probe(16'h5A5A, 20'h15A5A, "R1");
  endtask

  task automatic test_wrap();
    writeReg(2'd2, 8'hF8);
    probe(16'hF555, 20'h07555, "R6");
    probe(16'h8ABC, 20'h00ABC, "R6");
  endtask

  task automatic test_sel_none();
    writeReg(2'd3, 8'hFF);
    probe(16'h4123, 20'h14123, "R8");
    probe(16'h3ABC, 20'h03ABC, "R8");
    probe(16'h9000, 20'h01000, "R8");
  endtask

  task automatic test_no_enable();
    @(negedge clk);
    regWrEn = 1'b0;
    regSel = 2'd1;
    regWrData = 8'h77;
    @(negedge clk);
    regSel = 2'd0;
    regWrData = 8'h00;
    probe(16'h4123, 20'h14123, "R10");
    probe(16'h2000, 20'h02000, "R10");
  endtask

  task automatic test_same_cycle();
    @(negedge clk);
    logAddr = 16'h5000;
    regWrEn = 1'b1;
    regSel = 2'd1;
    regWrData = 8'h20;
    #1;
    compare(20'h15000, "R7 old mapping in write cycle");
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
    compare(20'h25000, "R7 new mapping after write edge");
  endtask

  task automatic test_inverted();
    writeReg(2'd0, 8'h26);
    writeReg(2'd2, 8'h40);
    probe(16'h1111, 20'h01111, "R9");
    probe(16'h3333, 20'h03333, "R9");
    probe(16'h6000, 20'h46000, "R9");
    probe(16'hFFFF, 20'h4FFFF, "R9");
  endtask

  task automatic test_zero_bank_start();
    writeReg(2'd0, 8'h00);
    probe(16'h0123, 20'h40123, "R5");
    writeReg(2'd0, 8'hF0);
    probe(16'hE000, 20'h2E000, "R4");
    probe(16'hF000, 20'h4F000, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_regions();
    test_wrap();
    test_sel_none();
    test_no_enable();
    writeReg(2'd2, 8'h30);
    test_same_cycle();
    test_inverted();
    test_zero_bank_start();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nMis++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
      $finish;
    end
  end

endmodule